// File: doc/BRIEF.md
# SPI Target Port with Shared-Pointer Circular Buffers

This block is the target (slave) end of an SPI link, running in clock-polarity-0 / phase-0 framing. It uses a receive buffer and a transmit buffer, each `DEPTH` bytes deep, and one byte pointer that indexes both. Each byte the controller shifts in on MOSI is stored at the pointer. During the same byte time, the byte held at that pointer in the transmit buffer is shifted out on MISO, MSB first. The pointer then advances. It wraps to zero after the last slot when wrap is on. When wrap is off, it parks at the last slot.

SCK, chip select and MOSI are asynchronous to `clk` and are oversampled. `clk` must run at least 4x SCK, and the SCK half period must be longer than the synchroniser delay plus two cycles. Local logic uses a plain register port to load the transmit buffer, read the receive buffer and the pointer, and set the controls. Every access completes in one cycle and the port never back-pressures. Writes take effect at the next edge, and `reg_rdata` shows the addressed location one cycle after `reg_addr` is presented.

Events are sticky and write-1-to-clear, and each can be enabled onto `irq`. The events are:
- chip-select assert
- chip-select release
- pointer reaching the half-buffer point
- the last slot being filled
- a programmable byte-count level
- end of a transaction that carried clocks

Top module: `spi_tgt`

## Requirements
- R1: After reset, the pointer reads 0, the event status reads 0, busy reads 0, and `irq` and `spi_miso` are 0.
- R2: While enabled, each group of 8 SCK rising edges with chip select low (active) shifts in one MOSI byte, MSB first. The byte is stored in the receive buffer at the pointer and the pointer then advances by one.
- R3: MISO carries, MSB first, the transmit-buffer byte at the current pointer. The first bit is present after chip select asserts. Each later bit follows an SCK falling edge. After each complete byte, the byte at the advanced pointer is loaded. While disabled, MISO is 0.
- R4: With wrap (CTRL bit 1) set, the byte stored at slot DEPTH-1 moves the pointer to 0. With wrap clear, the pointer stays at DEPTH-1 and later bytes are discarded, leaving the receive buffer unchanged.
- R5: Status bit 2 (half) is set when the pointer advances from DEPTH/2-1 to DEPTH/2. Status bit 3 (full) is set when a byte is stored at slot DEPTH-1.
- R6: The level register holds a threshold in bits 6:0 and a disable flag in bit 7, and it resets disabled. When the flag is clear and the threshold is non-zero, status bit 4 is set on the byte that makes the count since chip-select assert equal to the threshold. Writing the register with bit 7 set disarms it.
- R7: Status bit 0 is set on chip-select assert. Status bit 1 is set on chip-select release, even when no SCK edge occurred.
- R8: Status bit 5 (end of transaction) is set on chip-select release only if at least one SCK rising edge occurred while chip select was asserted.
- R9: STATUS register bit 0 (busy) reads 1 while the synchronised chip select is asserted and 0 otherwise.
- R10: While CTRL bit 0 (enable) is 0, the pointer is held at 0, all event status bits are cleared, nothing is stored and no event is raised.
- R11: Writing a 1 to an event status bit clears it and leaves the other bits unchanged. A set in the same cycle wins.
- R12: `irq` is 1 exactly when some event status bit and its enable bit (IEN register, same bit position) are both 1.
- R13: `reg_addr[8:7]` selects the register space: 00 control registers, 01 transmit buffer, 10 receive buffer. Within the control space, the low three address bits select CTRL=0, IEN=1, STAT=2, PTR=3, LEVEL=4 and STATUS=5. The read data is registered with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the controller, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| reg_addr | input | 9 | Register-port address (space in bits 8:7, offset in 6:0) |
| reg_wr | input | 1 | Register-port write strobe |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq | output | 1 | OR of enabled event status bits |

## Verification
The bench builds the block with its defaults: DEPTH of 128 and two synchroniser stages. SCK runs at sixteen system clocks per period. A full buffer's worth of bytes in one transaction is therefore affordable, so both the half and the full events, the parked pointer and the discarded byte with wrap off, and the wrap back to slot 0 are all reached. A scoreboard queue holds the MISO byte expected for every transfer, taken from a model of the transmit buffer and pointer. This checks the load-on-falling-edge ordering across byte boundaries, in the parked state, and while disabled.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int EV_CSF  = 0;
  localparam int EV_CSR  = 1;
  localparam int EV_HALF = 2;
  localparam int EV_FULL = 3;
  localparam int EV_LVL  = 4;
  localparam int EV_EOR  = 5;
  localparam int NEV     = 6;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_IEN  = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_PTR  = 3'd3;
  localparam logic [2:0] RA_LVL  = 3'd4;
  localparam logic [2:0] RA_STS  = 3'd5;

  typedef enum logic [1:0] {
    SP_CTRL = 2'b00,
    SP_OBUF = 2'b01,
    SP_IBUF = 2'b10,
    SP_NONE = 2'b11
  } space_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE}};
      prev  <= IDLE;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cs_act,
  input  logic       start,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic       miso
);
  logic [2:0] bitc;
  logic [7:0] rxsr;
  logic [7:0] txsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitc     <= '0;
      rxsr     <= '0;
      txsr     <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!en) begin
        bitc <= '0;
        txsr <= '0;
      end else if (start) begin
        bitc <= '0;
        txsr <= tx_byte;
      end else if (cs_act) begin
        if (sck_rise) begin
          rxsr <= {rxsr[6:0], mosi};
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            byte_vld <= 1'b1;
            byte_dat <= {rxsr[6:0], mosi};
          end
        end else if (sck_fall) begin
          if (bitc == 3'd0) txsr <= tx_byte;
          else              txsr <= {txsr[6:0], 1'b0};
        end
      end
    end
  end

  assign miso = txsr[7];
endmodule

// File: rtl/spi_evt_reg.sv
module spi_evt_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] set,
  input  logic         w1c_we,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] stat
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   b <= 1'b0;
      else if (clr_all)             b <= 1'b0;
      else if (set[g])              b <= 1'b1;
      else if (w1c_we && w1c[g])    b <= 1'b0;
    end
    assign stat[g] = b;
  end
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sck,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  input  logic [$clog2(DEPTH)+1:0]  reg_addr,
  input  logic                      reg_wr,
  input  logic [7:0]                reg_wdata,
  output logic [7:0]                reg_rdata,
  output logic                      irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int AW    = PTR_W + 2;
  localparam int HALF  = DEPTH / 2;
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] MIDM1 = PTR_W'(HALF - 1);

  // pin synchronisation: {mosi, sck, cs_n}
  logic [2:0] s_lvl, s_rise, s_fall;
  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({spi_mosi, spi_sck, spi_cs_n}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );
  logic unused_mosi_edges;
  assign unused_mosi_edges = s_rise[2] ^ s_fall[2];

  logic cs_act, cs_on, cs_off;
  assign cs_act = ~s_lvl[0];
  assign cs_on  = s_fall[0];
  assign cs_off = s_rise[0];

  // control state
  logic             ctrl_en, ctrl_wrap, lvl_off;
  logic [NEV-1:0]   ien;
  logic [PTR_W-1:0] lvl_thr;
  logic [PTR_W-1:0] ptr;
  logic             stopped;
  logic [PTR_W:0]   rx_cnt;
  logic             clk_seen;
  logic [NEV-1:0]   stat;

  logic [7:0] obuf [DEPTH];
  logic [7:0] ibuf [DEPTH];

  space_e           space;
  logic [PTR_W-1:0] idx;
  assign space = space_e'(reg_addr[AW-1 -: 2]);
  assign idx   = reg_addr[PTR_W-1:0];

  logic ctl_wr;
  assign ctl_wr = reg_wr && (space == SP_CTRL);

  // serial engine
  logic       byte_vld;
  logic [7:0] byte_dat;
  spi_shift_core u_shift (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_en), .cs_act(cs_act), .start(cs_on),
    .sck_rise(s_rise[1]), .sck_fall(s_fall[1]), .mosi(s_lvl[2]),
    .tx_byte(obuf[ptr]),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .miso(spi_miso)
  );

  logic store;
  assign store = byte_vld && ctrl_en && !stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_wrap <= 1'b0;
      ien       <= '0;
      lvl_off   <= 1'b1;
      lvl_thr   <= '0;
    end else if (ctl_wr) begin
      case (idx[2:0])
        RA_CTRL: begin ctrl_en <= reg_wdata[0]; ctrl_wrap <= reg_wdata[1]; end
        RA_IEN:  ien <= reg_wdata[NEV-1:0];
        RA_LVL:  begin lvl_off <= reg_wdata[7]; lvl_thr <= reg_wdata[PTR_W-1:0]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      stopped  <= 1'b0;
      rx_cnt   <= '0;
      clk_seen <= 1'b0;
    end else if (!ctrl_en) begin
      ptr      <= '0;
      stopped  <= 1'b0;
      rx_cnt   <= '0;
      clk_seen <= 1'b0;
    end else begin
      if (store) begin
        if (ptr == LAST) begin
          if (ctrl_wrap) ptr <= '0;
          else           stopped <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (cs_on)                             rx_cnt <= '0;
      else if (byte_vld && rx_cnt != '1)     rx_cnt <= rx_cnt + 1'b1;
      if (cs_on)                             clk_seen <= 1'b0;
      else if (cs_act && s_rise[1])          clk_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && space == SP_OBUF) obuf[idx] <= reg_wdata;
    if (store)                      ibuf[ptr] <= byte_dat;
  end

  // events
  logic [NEV-1:0] ev_set;
  logic [PTR_W:0] rx_nxt;
  assign rx_nxt = rx_cnt + 1'b1;
  always_comb begin
    ev_set          = '0;
    ev_set[EV_CSF]  = cs_on;
    ev_set[EV_CSR]  = cs_off;
    ev_set[EV_HALF] = store && (ptr == MIDM1);
    ev_set[EV_FULL] = store && (ptr == LAST);
    ev_set[EV_LVL]  = byte_vld && !lvl_off && (lvl_thr != '0) && (rx_nxt == {1'b0, lvl_thr});
    ev_set[EV_EOR]  = cs_off && clk_seen;
  end

  spi_evt_reg #(.N(NEV)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr_all(!ctrl_en), .set(ev_set),
    .w1c_we(ctl_wr && idx[2:0] == RA_STAT), .w1c(reg_wdata[NEV-1:0]),
    .stat(stat)
  );

  assign irq = |(stat & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else begin
      case (space)
        SP_CTRL: begin
          case (idx[2:0])
            RA_CTRL: reg_rdata <= {6'd0, ctrl_wrap, ctrl_en};
            RA_IEN:  reg_rdata <= 8'(ien);
            RA_STAT: reg_rdata <= 8'(stat);
            RA_PTR:  reg_rdata <= 8'(ptr);
            RA_LVL:  reg_rdata <= {lvl_off, 7'(lvl_thr)};
            RA_STS:  reg_rdata <= {7'd0, cs_act};
            default: reg_rdata <= '0;
          endcase
        end
        SP_OBUF: reg_rdata <= obuf[idx];
        SP_IBUF: reg_rdata <= ibuf[idx];
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
  parameter int DEPTH = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     wrap,
  input logic                     byte_vld,
  input logic                     stopped,
  input logic [$clog2(DEPTH)-1:0] ptr,
  input logic                     stat_csf,
  input logic                     stat_half,
  input logic                     stat_full,
  input logic                     stat_eor,
  input logic                     stat_any,
  input logic                     cs_on,
  input logic                     cs_off
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] MIDM1 = PTR_W'(DEPTH / 2 - 1);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && byte_vld && !stopped && ptr != LAST |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en && wrap && byte_vld && !stopped && ptr == LAST |=> ptr == '0); // R4

  AST_HALF_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    en && byte_vld && !stopped && ptr == MIDM1 |=> stat_half); // R5

  AST_FULL_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    en && byte_vld && !stopped && ptr == LAST |=> stat_full); // R5

  AST_CS_ASSERT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    en && cs_on |=> stat_csf); // R7

  AST_EOR_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_eor) |-> $past(cs_off)); // R8

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ptr == '0 && !stat_any)); // R10
endmodule

bind spi_tgt spi_tgt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .wrap(ctrl_wrap),
  .byte_vld(byte_vld), .stopped(stopped), .ptr(ptr),
  .stat_csf(stat[spi_tgt_pkg::EV_CSF]), .stat_half(stat[spi_tgt_pkg::EV_HALF]),
  .stat_full(stat[spi_tgt_pkg::EV_FULL]), .stat_eor(stat[spi_tgt_pkg::EV_EOR]),
  .stat_any(|stat), .cs_on(cs_on), .cs_off(cs_off)
);

// File: tb/tb_spi_tgt.sv
module tb_spi_tgt;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int DEPTH      = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic [8:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tgt dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // model
  logic [7:0] m_ob [DEPTH];
  logic [7:0] m_ib [DEPTH];
  int  m_ptr = 0;
  bit  m_stop = 1'b0;
  bit  m_en = 1'b0;
  bit  m_wrap = 1'b0;
  logic [7:0] exp_q [$];

  task automatic check_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [8:0] actl(input int i);
    return {2'b00, 7'(i)};
  endfunction
  function automatic logic [8:0] aob(input int i);
    return {2'b01, 7'(i)};
  endfunction
  function automatic logic [8:0] aib(input int i);
    return {2'b10, 7'(i)};
  endfunction

  task automatic cs_low();
    @(negedge clk);
    spi_cs_n = 1'b0;
    tick(HALF_SCK);
  endtask

  task automatic cs_high();
    tick(HALF_SCK);
    spi_cs_n = 1'b1;
    tick(8);
  endtask

  // driver: pushes expected MISO byte, shifts one byte, updates model
  task automatic send(input logic [7:0] din);
    exp_q.push_back(m_en ? m_ob[m_ptr] : 8'h00);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = din[i];
      tick(HALF_SCK);
      spi_sck = 1'b1;
      tick(HALF_SCK);
      spi_sck = 1'b0;
    end
    if (m_en && !m_stop) begin
      m_ib[m_ptr] = din;
      if (m_ptr == DEPTH-1) begin
        if (m_wrap) m_ptr = 0; else m_stop = 1'b1;
      end else m_ptr++;
    end
  endtask

  // monitor: collects MISO on SCK rise, compares against scoreboard
  logic [7:0] mon_sr = '0;
  int         mon_n = 0;
  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      mon_sr = {mon_sr[6:0], spi_miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) check_eq("R3 unexpected byte", int'(mon_sr), -1);
        else check_eq("R3 miso byte", int'(mon_sr), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    reg_read(actl(2), d); check_eq("R1 stat", d, 0);
    reg_read(actl(3), d); check_eq("R1 ptr", d, 0);
    reg_read(actl(5), d); check_eq("R1 busy", d, 0);
    check_eq("R1 irq", irq, 0);
    check_eq("R1 miso", spi_miso, 0);

    // load transmit buffer (R13 space 01)
    for (int i = 0; i < DEPTH; i++) begin
      m_ob[i] = 8'(i * 5 + 3) ^ 8'h5A;
      reg_write(aob(i), m_ob[i]);
    end
    reg_read(aob(9), d); check_eq("R13 obuf readback", d, m_ob[9]);

    reg_write(actl(0), 8'h01); m_en = 1'b1;
    reg_read(actl(0), d); check_eq("R13 ctrl readback", d, 1);

    // basic transaction
    cs_low();
    reg_read(actl(5), d); check_eq("R9 busy during cs", d, 1);
    reg_read(actl(2), d); check_eq("R7 cs assert event", d, 8'h01);
    send(8'hA5); send(8'h3C); send(8'hFF); send(8'h00);
    cs_high();
    reg_read(actl(5), d); check_eq("R9 busy after release", d, 0);
    reg_read(aib(0), d); check_eq("R2 ibuf0", d, 8'hA5);
    reg_read(aib(1), d); check_eq("R2 ibuf1", d, 8'h3C);
    reg_read(aib(2), d); check_eq("R2 ibuf2", d, 8'hFF);
    reg_read(aib(3), d); check_eq("R2 ibuf3", d, 8'h00);
    reg_read(actl(3), d); check_eq("R2 ptr", d, 4);
    reg_read(actl(2), d); check_eq("R7 R8 stat after clocked txn", d, 8'h23);

    // R11 write-1-to-clear
    reg_write(actl(2), 8'h01);
    reg_read(actl(2), d); check_eq("R11 w1c single bit", d, 8'h22);

    // R12 irq masking
    reg_write(actl(1), 8'h02); tick(1);
    check_eq("R12 irq enabled bit", irq, 1);
    reg_write(actl(1), 8'h01); tick(1);
    check_eq("R12 irq masked", irq, 0);
    reg_write(actl(2), 8'hFF);
    reg_read(actl(2), d); check_eq("R11 clear all", d, 0);
    reg_write(actl(1), 8'h00);

    // chip-select pulse with no clocks
    cs_low(); cs_high();
    reg_read(actl(2), d); check_eq("R7 R8 release without clocks", d, 8'h03);
    reg_write(actl(2), 8'hFF);

    // R6 level event armed
    reg_write(actl(4), 8'h83);
    reg_write(actl(4), 8'h03);
    cs_low();
    send(8'h11); send(8'h22);
    reg_read(actl(2), d); check_eq("R6 level not yet", int'(d[4]), 0);
    send(8'h33);
    reg_read(actl(2), d); check_eq("R6 level reached", int'(d[4]), 1);
    cs_high();
    reg_write(actl(2), 8'hFF);
    // R6 disarmed
    reg_write(actl(4), 8'h83);
    cs_low(); send(8'h44); send(8'h55); send(8'h66); cs_high();
    reg_read(actl(2), d); check_eq("R6 level disarmed", int'(d[4]), 0);
    reg_write(actl(2), 8'hFF);

    // R5 half, R4 no-wrap park
    cs_low();
    while (m_ptr < DEPTH/2) send(8'(m_ptr * 7 + 1));
    reg_read(actl(2), d); check_eq("R5 half set", int'(d[2]), 1);
    check_eq("R5 full not yet", int'(d[3]), 0);
    reg_read(actl(3), d); check_eq("R5 ptr at half", d, DEPTH/2);
    while (m_ptr < DEPTH-1) send(8'(m_ptr * 7 + 1));
    reg_read(actl(2), d); check_eq("R5 full not before last", int'(d[3]), 0);
    send(8'hE1);
    reg_read(actl(2), d); check_eq("R5 full set", int'(d[3]), 1);
    reg_read(actl(3), d); check_eq("R4 parked ptr", d, DEPTH-1);
    send(8'h77);
    reg_read(aib(DEPTH-1), d); check_eq("R4 discarded byte", d, 8'hE1);
    reg_read(actl(3), d); check_eq("R4 ptr still parked", d, DEPTH-1);
    cs_high();
    reg_read(aib(DEPTH/2), d); check_eq("R2 ibuf mid", d, m_ib[DEPTH/2]);

    // R10 disable
    reg_write(actl(0), 8'h00); m_en = 1'b0; m_ptr = 0; m_stop = 1'b0;
    reg_read(actl(3), d); check_eq("R10 ptr cleared", d, 0);
    reg_read(actl(2), d); check_eq("R10 stat cleared", d, 0);
    cs_low(); send(8'h11); cs_high();
    reg_read(actl(2), d); check_eq("R10 no events", d, 0);
    reg_read(aib(0), d); check_eq("R10 no store", d, 8'hA5);
    reg_read(actl(3), d); check_eq("R10 ptr held", d, 0);

    // R4 wrap
    reg_write(actl(0), 8'h03); m_en = 1'b1; m_wrap = 1'b1;
    cs_low();
    for (int k = 0; k < DEPTH; k++) send(8'(k ^ 8'h96));
    reg_read(actl(2), d); check_eq("R5 full with wrap", int'(d[3]), 1);
    reg_read(actl(3), d); check_eq("R4 wrapped ptr", d, 0);
    send(8'hC3);
    cs_high();
    reg_read(aib(0), d); check_eq("R4 stored after wrap", d, 8'hC3);
    reg_read(actl(3), d); check_eq("R4 ptr after wrap", d, 1);
    reg_read(aib(DEPTH-1), d); check_eq("R2 last slot", d, m_ib[DEPTH-1]);

    check_eq("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule